// File: doc/BRIEF.md
# D-PHY Clock Lane Sequencer

This block sequences one MIPI D-PHY clock lane between the low-power stop state and continuous high-speed clocking. It runs on the byte clock. When a clock request arrives, it steps the lane through a low-power request state and a low-power bridge state, then drives HS-0 and finally enables the toggling clock. Once toggling has begun it raises an acknowledge, which tells the data lane sequencers that they may start their own transfers.

Shutdown starts only when the request has been withdrawn and every data lane reports that it has finished its trail. The clock then keeps toggling for a post period and holds HS-0 for a trail period. It returns to LP-11 and stays there for an exit period before it accepts another start. Every dwell time comes from one of two packed timing words and is counted in byte-clock cycles. For example, at a 54 MHz byte clock a zero count of 14 lasts about 259 ns and a post count of 10 lasts about 185 ns.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: After reset, and while no request has arrived, the lane shows LP-11 (`lp_o` = 2'b11, where `lp_o[1]` is the positive line and `lp_o[0]` the negative line), and `hs_en_o`, `clk_tog_o` and `clk_active_o` are all low.
- R2: A request that the sequencer samples high in the idle state produces LP-01 (`lp_o` = 2'b01) from the next cycle onward, for exactly the lpx count, where lpx = `tim0_i[15:8]`.
- R3: LP-01 is followed by LP-00 (`lp_o` = 2'b00, `hs_en_o` low) for exactly the prepare count, where prepare = `tim1_i[31:24]`.
- R4: LP-00 is followed by HS-0 (`lp_o` = 2'b00, `hs_en_o` high, `clk_tog_o` low) for exactly the zero count, where zero = `tim1_i[23:16]`.
- R5: After HS-0, `clk_tog_o` and `clk_active_o` rise together in the first toggling cycle. `clk_active_o` is never high outside that running state.
- R6: While running, the lane keeps toggling with `clk_active_o` high as long as the request is high or `data_idle_i` is low.
- R7: When the request is low and `data_idle_i` is high in the running state, `clk_active_o` drops in the next cycle and toggling continues for exactly the post count, where post = `tim1_i[15:8]`.
- R8: After the post period the lane holds HS-0 for exactly the trail count (trail = `tim1_i[7:0]`) and then shows LP-11.
- R9: After the trail period, LP-11 lasts exactly the exit count (exit = `tim0_i[7:0]`), even if a request is pending. A pending request then starts LP-01 in the very next cycle.
- R10: A timing field of zero gives a one-cycle dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_req_i | input | 1 | Request for the continuous HS clock |
| data_idle_i | input | 1 | High when every data lane has finished its trail |
| tim0_i | input | 32 | Timing word 0: lpx in [15:8], exit in [7:0] |
| tim1_i | input | 32 | Timing word 1: prepare [31:24], zero [23:16], post [15:8], trail [7:0] |
| lp_o | output | 2 | Low-power line state {positive, negative} |
| hs_en_o | output | 1 | High-speed driver enable |
| clk_tog_o | output | 1 | Enables the toggling DDR clock |
| clk_active_o | output | 1 | Clock running; the data lanes may begin |

## Verification
The bench builds the block with its defaults: 8-bit fields in 32-bit words, with a zero field mapped to one cycle. This lets one vector table cover the typical word pair, an all-zero pair that exercises every one-cycle dwell, and pairs with uneven and long counts such as a 64-cycle zero period. Each phase length is measured at the pins and compared with the field it comes from. Directed steps then hold the stop back with busy data lanes, issue a request during the exit hold, and reset the block while it is running.

// File: rtl/dcls_pkg.sv
package dcls_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LPREQ = 3'd1,
      ST_PREP  = 3'd2,
      ST_ZERO  = 3'd3,
      ST_RUN   = 3'd4,
      ST_POST  = 3'd5,
      ST_TRAIL = 3'd6,
      ST_EXIT  = 3'd7
   } lane_st_e;

   // slot numbers: word-1 fields use the byte slot they occupy
   localparam int D_TRAIL = 0;
   localparam int D_POST  = 1;
   localparam int D_ZERO  = 2;
   localparam int D_PREP  = 3;
   localparam int D_EXIT  = 4;
   localparam int D_LPX   = 5;
   localparam int N_DUR   = 6;

   localparam logic [1:0] LP_STOP   = 2'b11;
   localparam logic [1:0] LP_REQ    = 2'b01;
   localparam logic [1:0] LP_BRIDGE = 2'b00;

endpackage

// File: rtl/dcls_tim_unpack.sv
module dcls_tim_unpack
   import dcls_pkg::*;
#(
   parameter int FIELD_W     = 8,
   parameter int WORD_W      = 32,
   parameter bit ZERO_IS_ONE = 1'b1,
   localparam int CNT_W      = FIELD_W + 1
) (
   input  logic [WORD_W-1:0]             tim0_i,
   input  logic [WORD_W-1:0]             tim1_i,
   output logic [N_DUR-1:0][CNT_W-1:0]   dur_o
);

   logic [N_DUR-1:0][FIELD_W-1:0] raw;

   // word 1 carries four fields, one per slot
   for (genvar s = 0; s < 4; s++) begin : g_w1
      assign raw[s] = tim1_i[s*FIELD_W +: FIELD_W];
   end
   // word 0 carries two fields in its low slots
   for (genvar s = 0; s < 2; s++) begin : g_w0
      assign raw[D_EXIT+s] = tim0_i[s*FIELD_W +: FIELD_W];
   end

   logic unused_w0;
   assign unused_w0 = ^tim0_i[WORD_W-1:2*FIELD_W];
   if (WORD_W > 4*FIELD_W) begin : g_w1_spare
      logic unused_w1;
      assign unused_w1 = ^tim1_i[WORD_W-1:4*FIELD_W];
   end

   for (genvar d = 0; d < N_DUR; d++) begin : g_dur
      if (ZERO_IS_ONE) begin : g_floor
         assign dur_o[d] = (raw[d] == '0) ? CNT_W'(1) : {1'b0, raw[d]};
      end else begin : g_wrap
         // zero stands for the full field range
         assign dur_o[d] = (raw[d] == '0) ? (CNT_W'(1) << FIELD_W) : {1'b0, raw[d]};
      end
   end

endmodule

// File: rtl/dcls_dwell_cnt.sv
module dcls_dwell_cnt #(
   parameter int CNT_W = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last_o = (cnt_q == CNT_W'(1));

   // R10: every load comes from a sanitised field, so a dwell is never empty
   a_r10_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (val_i != '0));

   // R10: a loaded dwell counts down one step per cycle
   a_r10_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/dcls_seq_fsm.sv
module dcls_seq_fsm
   import dcls_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        req_i,
   input  logic                        data_idle_i,
   input  logic [N_DUR-1:0][CNT_W-1:0] dur_i,
   input  logic                        last_i,
   output logic                        load_o,
   output logic [CNT_W-1:0]            load_val_o,
   output logic [1:0]                  lp_o,
   output logic                        hs_en_o,
   output logic                        tog_o,
   output logic                        active_o
);

   lane_st_e st_q, st_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   always_comb begin
      st_d       = st_q;
      load_o     = 1'b0;
      load_val_o = '0;
      unique case (st_q)
         ST_IDLE: if (req_i) begin
            st_d = ST_LPREQ;  load_o = 1'b1;  load_val_o = dur_i[D_LPX];
         end
         ST_LPREQ: if (last_i) begin
            st_d = ST_PREP;   load_o = 1'b1;  load_val_o = dur_i[D_PREP];
         end
         ST_PREP: if (last_i) begin
            st_d = ST_ZERO;   load_o = 1'b1;  load_val_o = dur_i[D_ZERO];
         end
         ST_ZERO: if (last_i) begin
            st_d = ST_RUN;
         end
         ST_RUN: if (!req_i && data_idle_i) begin
            st_d = ST_POST;   load_o = 1'b1;  load_val_o = dur_i[D_POST];
         end
         ST_POST: if (last_i) begin
            st_d = ST_TRAIL;  load_o = 1'b1;  load_val_o = dur_i[D_TRAIL];
         end
         ST_TRAIL: if (last_i) begin
            st_d = ST_EXIT;   load_o = 1'b1;  load_val_o = dur_i[D_EXIT];
         end
         ST_EXIT: if (last_i) begin
            if (req_i) begin
               st_d = ST_LPREQ;  load_o = 1'b1;  load_val_o = dur_i[D_LPX];
            end else begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   // output decode from the registered state
   always_comb begin
      lp_o     = LP_BRIDGE;
      hs_en_o  = 1'b0;
      tog_o    = 1'b0;
      active_o = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_EXIT: lp_o = LP_STOP;
         ST_LPREQ:         lp_o = LP_REQ;
         ST_PREP:          lp_o = LP_BRIDGE;
         ST_ZERO, ST_TRAIL: hs_en_o = 1'b1;
         ST_RUN: begin
            hs_en_o = 1'b1;  tog_o = 1'b1;  active_o = 1'b1;
         end
         ST_POST: begin
            hs_en_o = 1'b1;  tog_o = 1'b1;
         end
         default: lp_o = LP_STOP;
      endcase
   end

   a_r2_idle_accepts_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && req_i) |=> (lp_o == LP_REQ));

   a_r5_ack_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active_o) |-> ($past(st_q) == ST_ZERO && tog_o));

   a_r6_hold_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && (req_i || !data_idle_i)) |=> (active_o && tog_o));

   a_r7_post_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && !req_i && data_idle_i) |=> (tog_o && !active_o));

   a_r8_trail_to_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_TRAIL && last_i) |=> (lp_o == LP_STOP && !hs_en_o));

   a_r9_exit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_EXIT && !last_i) |=> (lp_o == LP_STOP));

endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
   import dcls_pkg::*;
#(
   parameter int FIELD_W     = 8,
   parameter int WORD_W      = 32,
   parameter bit ZERO_IS_ONE = 1'b1,
   localparam int CNT_W      = FIELD_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clk_req_i,
   input  logic              data_idle_i,
   input  logic [WORD_W-1:0] tim0_i,
   input  logic [WORD_W-1:0] tim1_i,
   output logic [1:0]        lp_o,
   output logic              hs_en_o,
   output logic              clk_tog_o,
   output logic              clk_active_o
);

   initial begin
      assert (FIELD_W >= 2) else $error("FIELD_W must be at least 2");
      assert (WORD_W >= 4*FIELD_W) else $error("WORD_W must hold four fields");
   end

   logic [N_DUR-1:0][CNT_W-1:0] dur;
   logic                        load;
   logic [CNT_W-1:0]            load_val;
   logic                        last;

   dcls_tim_unpack #(
      .FIELD_W     (FIELD_W),
      .WORD_W      (WORD_W),
      .ZERO_IS_ONE (ZERO_IS_ONE)
   ) u_unpack (
      .tim0_i (tim0_i),
      .tim1_i (tim1_i),
      .dur_o  (dur)
   );

   dcls_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .val_i  (load_val),
      .last_o (last)
   );

   dcls_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (clk_req_i),
      .data_idle_i (data_idle_i),
      .dur_i       (dur),
      .last_i      (last),
      .load_o      (load),
      .load_val_o  (load_val),
      .lp_o        (lp_o),
      .hs_en_o     (hs_en_o),
      .tog_o       (clk_tog_o),
      .active_o    (clk_active_o)
   );

   a_r5_ack_only_toggling: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_active_o |-> (clk_tog_o && hs_en_o && lp_o == LP_BRIDGE));

   a_r4_hs_leaves_lp_bridge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_en_o |-> (lp_o == LP_BRIDGE));

endmodule

// File: tb/dphy_clk_lane_seq_bench.sv
`timescale 1ns/1ps
module dphy_clk_lane_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        didle = 1'b1;
   logic [31:0] w0 = 32'h0;
   logic [31:0] w1 = 32'h0;
   logic [1:0]  lp;
   logic        hs, tog, act;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dphy_clk_lane_seq u_dphy_clk_lane_seq (
      .clk_i(clk), .rst_ni(rst_n), .clk_req_i(req), .data_idle_i(didle),
      .tim0_i(w0), .tim1_i(w1), .lp_o(lp), .hs_en_o(hs),
      .clk_tog_o(tog), .clk_active_o(act)
   );

   // observed pin code {lp, hs, tog, act}
   localparam logic [4:0] C_STOP = 5'b11_000;
   localparam logic [4:0] C_REQ  = 5'b01_000;
   localparam logic [4:0] C_PREP = 5'b00_000;
   localparam logic [4:0] C_HS0  = 5'b00_100;
   localparam logic [4:0] C_RUN  = 5'b00_111;
   localparam logic [4:0] C_POST = 5'b00_110;

   // {word0, word1}
   localparam logic [63:0] VECS [0:3] = '{
      {32'h0000_0306, 32'h030E_0A04},
      {32'h0000_0000, 32'h0000_0000},
      {32'h0000_0102, 32'h0501_0207},
      {32'hFFFF_2001, 32'h0240_0311}
   };

   function automatic logic [4:0] code();
      return {lp, hs, tog, act};
   endfunction

   function automatic int fd(input logic [7:0] b);
      return (b == 8'd0) ? 1 : int'(b);
   endfunction

   task automatic chk(input string tag, input int actual, input int expected);
      n_run++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic count_code(input logic [4:0] c, output int n);
      n = 0;
      while (code() == c && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input logic [31:0] a, input logic [31:0] b);
      int n;
      w0 = a;  w1 = b;  didle = 1'b1;
      req = 1'b1;
      @(negedge clk);
      count_code(C_REQ, n);   chk("R2 lpx dwell", n, fd(a[15:8]));
      count_code(C_PREP, n);  chk("R3 prepare dwell", n, fd(b[31:24]));
      count_code(C_HS0, n);   chk("R4 zero dwell", n, fd(b[23:16]));
      chk("R5 toggle and ack together", int'(code()), int'(C_RUN));
      repeat (5) @(negedge clk);
      chk("R6 running while requested", int'(code()), int'(C_RUN));
      req = 1'b0;  didle = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 running while data busy", int'(code()), int'(C_RUN));
      didle = 1'b1;
      @(negedge clk);
      count_code(C_POST, n);  chk("R7 post dwell", n, fd(b[15:8]));
      req = 1'b1;
      count_code(C_HS0, n);   chk("R8 trail dwell", n, fd(b[7:0]));
      count_code(C_STOP, n);  chk("R9 exit dwell with request", n, fd(a[7:0]));
      chk("R9 restart after exit", int'(code()), int'(C_REQ));
      n = 0;
      while (code() != C_RUN && n < 2000) begin n++; @(negedge clk); end
      req = 1'b0;
      repeat (300) @(negedge clk);
      chk("R1 back to stop", int'(code()), int'(C_STOP));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 stop in reset", int'(code()), int'(C_STOP));
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 stop without request", int'(code()), int'(C_STOP));

      for (int i = 0; i < 4; i++) begin
         run_vec(VECS[i][63:32], VECS[i][31:0]);
      end

      // R10: all-zero words give one-cycle dwells (vector 1 above); repeat once directly
      w0 = 32'h0;  w1 = 32'h0;  req = 1'b1;
      @(negedge clk);
      chk("R10 zero lpx one cycle", int'(code()), int'(C_REQ));
      @(negedge clk);
      chk("R10 zero prepare one cycle", int'(code()), int'(C_PREP));
      @(negedge clk);
      chk("R10 zero zero-count one cycle", int'(code()), int'(C_HS0));
      @(negedge clk);
      chk("R5 running after one-cycle zero", int'(code()), int'(C_RUN));

      // reset while running
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset while running", int'(code()), int'(C_STOP));
      req = 1'b0;
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle after reset", int'(code()), int'(C_STOP));

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule